// File: doc/BRIEF.md
# Clock and Data Phase Distorter

This block takes a clean serial bit stream and produces an output clock line and an output data line whose timing can be bent on purpose. Test equipment uses it to stress a receiver. All timing runs on an oversampling enable, `tick_en`, that fires eight times per bit, so one tick is 12.5% of a unit interval. Inside the block a reference clock and a reference data line are formed. Each one passes through its own tapped delay line. The nominal delay is two ticks, so the data can be moved earlier or later than the clock, and each line can also be moved independently.

The configuration inputs select one of these behaviours: a fixed data lead, a fixed data lag, jitter on the clock, jitter on the data, jitter on both, or a clock turned 180°. The jitter sign is drawn once per bit from an internal LFSR. A rate-class input states how fast the link runs. The block refuses any setting that is not allowed at that rate: it raises an error flag and sends the stream through undistorted. The configuration is taken on the last tick of each bit, so a change always starts cleanly at a bit boundary.

Top module: `clk_data_distorter`

## Requirements
- R1: While reset is asserted and before the first tick, `clk_out`, `dat_out`, `cfg_err` and `dist_active` are all 0.
- R2: Ticks are numbered from the first enabled tick after reset. Bit window j covers ticks 8j to 8j+7. In each window the reference clock is high for the first four ticks and low for the last four. The reference data in window j is the `din` value sampled on the last tick of window j-1, and it is 0 in window 0. With no distortion, after every tick each output shows its reference line as it stood two ticks earlier. The output clock therefore keeps a 50% duty cycle.
- R3: `mode_sel`=1 (data lead) sets the data delay to 2 minus A ticks and leaves the clock at 2 ticks. A is 1 tick for `amt_sel`=0 and 2 ticks for `amt_sel`=1.
- R4: `mode_sel`=2 (data lag) sets the data delay to 2 plus A ticks and leaves the clock at 2 ticks.
- R5: `mode_sel`=3 (clock jitter) sets the clock delay in each bit window to either 2-A or 2+A, chosen per window, and both signs occur over a run. The clock stays high for exactly four ticks. The data stays at 2 ticks.
- R6: `mode_sel`=4 (data jitter) sets the data delay in each bit window to either 2-A or 2+A, chosen per window, and both signs occur. The clock stays at 2 ticks.
- R7: `mode_sel`=5 (joint jitter) gives each line its own per-window delay of 2-1 or 2+1 ticks. With `amt_sel`=1 the setting is illegal.
- R8: `mode_sel`=6 outputs the complement of the nominal clock. The data stays nominal.
- R9: With `rate_sel` 2 or 3 (high rate), every mode except 0 is illegal.
- R10: With `rate_sel`=1 (mid rate), only modes 1 to 4 with `amt_sel`=1 are legal. Modes 1 to 4 with `amt_sel`=0 are rejected, and so are modes 5 and 6.
- R11: `mode_sel`=7 is illegal at every rate.
- R12: The configuration is sampled on the last tick of each bit window. Delays, inversion, `cfg_err` and `dist_active` all change only at that tick. When a setting is illegal, `cfg_err` is 1 and both delays go back to 2 ticks with no inversion.
- R13: `dist_active` is 1 exactly when a legal setting with a mode other than 0 is in force. It is never 1 while `cfg_err` is 1.
- R14: A cycle with `tick_en` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Tick enable, eight per bit |
| din | input | 1 | Serial data, sampled on the last tick of a bit |
| mode_sel | input | 3 | Distortion mode (0 none .. 7 reserved) |
| amt_sel | input | 1 | Amount: 0 = one tick, 1 = two ticks |
| rate_sel | input | 2 | Rate class: 0 low, 1 mid, 2/3 high |
| clk_out | output | 1 | Distorted clock line |
| dat_out | output | 1 | Distorted data line |
| cfg_err | output | 1 | Current setting rejected |
| dist_active | output | 1 | A distortion is being applied |

## Verification
The assertions assume that `mode_sel`, `amt_sel` and `rate_sel` are synchronous to `clk` and hold defined values on every boundary tick. They also assume that `tick_en` stays low while the reset synchronizer releases. The stimulus changes the configuration only at falling clock edges between whole bit windows, and it holds `tick_en` low through reset release. The bench cannot predict the jitter signs, so it accepts either delay for a window, provided one delay fits every tick of that window. It then requires both signs to appear.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [2:0] {
    PD_NONE     = 3'd0,
    PD_LEAD     = 3'd1,
    PD_LAG      = 3'd2,
    PD_JIT_CLK  = 3'd3,
    PD_JIT_DAT  = 3'd4,
    PD_JIT_BOTH = 3'd5,
    PD_CLK_INV  = 3'd6,
    PD_RSVD     = 3'd7
  } pd_mode_e;

  typedef enum logic [1:0] {
    RATE_LOW  = 2'd0,
    RATE_MID  = 2'd1,
    RATE_HIGH = 2'd2,
    RATE_TOP  = 2'd3
  } pd_rate_e;

  localparam int LFSR_W = 16;

  // Legality of a setting at a rate class; quarter selects the two-tick amount.
  function automatic logic pd_setting_ok(pd_mode_e m, logic quarter, pd_rate_e r);
    logic ok;
    if (m == PD_NONE) begin
      ok = 1'b1;
    end else if (m == PD_RSVD) begin
      ok = 1'b0;
    end else if (r == RATE_HIGH || r == RATE_TOP) begin
      ok = 1'b0;
    end else if (m == PD_JIT_BOTH && quarter) begin
      ok = 1'b0;
    end else if (r == RATE_MID) begin
      ok = quarter && (m == PD_LEAD || m == PD_LAG ||
                       m == PD_JIT_CLK || m == PD_JIT_DAT);
    end else begin
      ok = 1'b1;
    end
    return ok;
  endfunction

  // Maximal-length Fibonacci step, taps 16,14,13,11.
  function automatic logic [LFSR_W-1:0] pd_lfsr_next(logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/pd_rst_sync.sv
module pd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/pd_phase.sv
// Tick phase counter; builds the reference clock and data lines.
module pd_phase #(
  parameter int TPB  = 8,
  parameter int PH_W = $clog2(TPB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            din,
  output logic [PH_W-1:0] ph,
  output logic            bit_end,
  output logic            ref_clk,
  output logic            ref_dat
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TPB - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(TPB / 2);

  logic [PH_W-1:0] ph_d;
  logic            dat_q;
  logic            dat_d;

  assign bit_end = tick_en && (ph == PH_LAST);
  assign ref_clk = (ph < PH_HALF);
  assign ref_dat = dat_q;

  always_comb begin
    ph_d  = ph;
    dat_d = dat_q;
    if (tick_en) begin
      ph_d = bit_end ? '0 : ph + 1'b1;
      if (bit_end) dat_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      dat_q <= 1'b0;
    end else begin
      ph    <= ph_d;
      dat_q <= dat_d;
    end
  end
endmodule

// File: rtl/pd_ctrl.sv
// Per-bit configuration: legality, tap selection, jitter sign source.
module pd_ctrl
  import pd_pkg::*;
#(
  parameter int              TPB   = 8,
  parameter int              TAP_W = 3,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_end,
  input  logic [2:0]        mode_sel,
  input  logic              amt_sel,
  input  logic [1:0]        rate_sel,
  output logic [TAP_W-1:0]  clk_tap,
  output logic [TAP_W-1:0]  dat_tap,
  output logic              clk_inv,
  output logic              cfg_err,
  output logic              dist_active,
  output logic [LFSR_W-1:0] lfsr_q
);
  localparam int STEP = TPB / 8;
  localparam int NOM  = 2 * STEP;
  localparam logic [TAP_W-1:0] T_NOM  = TAP_W'(NOM);
  localparam logic [TAP_W-1:0] T_E_LO = TAP_W'(NOM - STEP);
  localparam logic [TAP_W-1:0] T_E_HI = TAP_W'(NOM + STEP);
  localparam logic [TAP_W-1:0] T_Q_LO = TAP_W'(NOM - 2 * STEP);
  localparam logic [TAP_W-1:0] T_Q_HI = TAP_W'(NOM + 2 * STEP);

  pd_mode_e          mode;
  pd_rate_e          rate;
  logic              legal;
  logic [TAP_W-1:0]  lo_tap;
  logic [TAP_W-1:0]  hi_tap;
  logic [TAP_W-1:0]  clk_tap_d;
  logic [TAP_W-1:0]  dat_tap_d;
  logic              inv_d;
  logic              err_d;
  logic              act_d;
  logic [LFSR_W-1:0] lfsr_d;
  logic              sgn_c;
  logic              sgn_d;

  assign mode  = pd_mode_e'(mode_sel);
  assign rate  = pd_rate_e'(rate_sel);
  assign legal = pd_setting_ok(mode, amt_sel, rate);
  assign sgn_c = lfsr_q[0];
  assign sgn_d = lfsr_q[7];

  always_comb begin
    clk_tap_d = T_NOM;
    dat_tap_d = T_NOM;
    inv_d     = 1'b0;
    lo_tap    = amt_sel ? T_Q_LO : T_E_LO;
    hi_tap    = amt_sel ? T_Q_HI : T_E_HI;
    if (legal) begin
      case (mode)
        PD_LEAD:     dat_tap_d = lo_tap;
        PD_LAG:      dat_tap_d = hi_tap;
        PD_JIT_CLK:  clk_tap_d = sgn_c ? hi_tap : lo_tap;
        PD_JIT_DAT:  dat_tap_d = sgn_d ? hi_tap : lo_tap;
        PD_JIT_BOTH: begin
          clk_tap_d = sgn_c ? T_E_HI : T_E_LO;
          dat_tap_d = sgn_d ? T_E_HI : T_E_LO;
        end
        PD_CLK_INV:  inv_d = 1'b1;
        default:     ;
      endcase
    end
    err_d  = !legal;
    act_d  = legal && (mode != PD_NONE);
    lfsr_d = pd_lfsr_next(lfsr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_tap     <= T_NOM;
      dat_tap     <= T_NOM;
      clk_inv     <= 1'b0;
      cfg_err     <= 1'b0;
      dist_active <= 1'b0;
      lfsr_q      <= SEED;
    end else if (bit_end) begin
      clk_tap     <= clk_tap_d;
      dat_tap     <= dat_tap_d;
      clk_inv     <= inv_d;
      cfg_err     <= err_d;
      dist_active <= act_d;
      lfsr_q      <= lfsr_d;
    end
  end
endmodule

// File: rtl/pd_lane.sv
// Tapped delay line on the tick grid with a registered output.
module pd_lane #(
  parameter int DEPTH = 4,
  parameter int TAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ref_in,
  input  logic [TAP_W-1:0] tap,
  input  logic             flip,
  output logic             lane_out
);
  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;
  logic [DEPTH:0]   line;
  logic             out_d;

  assign line = {hist_q, ref_in};

  always_comb begin
    hist_d = hist_q;
    out_d  = lane_out;
    if (tick_en) begin
      hist_d = line[DEPTH-1:0];
      out_d  = line[tap] ^ flip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      lane_out <= 1'b0;
    end else begin
      hist_q   <= hist_d;
      lane_out <= out_d;
    end
  end
endmodule

// File: rtl/clk_data_distorter.sv
module clk_data_distorter
  import pd_pkg::*;
#(
  parameter int                TICKS_PER_BIT = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED     = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       din,
  input  logic [2:0] mode_sel,
  input  logic       amt_sel,
  input  logic [1:0] rate_sel,
  output logic       clk_out,
  output logic       dat_out,
  output logic       cfg_err,
  output logic       dist_active
);
  localparam int STEP  = TICKS_PER_BIT / 8;
  localparam int DEPTH = 4 * STEP;
  localparam int TAP_W = $clog2(DEPTH + 1);
  localparam int PH_W  = $clog2(TICKS_PER_BIT);
  localparam int LANES = 2;

  logic              rst_q_n;
  logic [PH_W-1:0]   ph;
  logic              bit_end;
  logic              ref_clk;
  logic              ref_dat;
  logic [TAP_W-1:0]  clk_tap;
  logic [TAP_W-1:0]  dat_tap;
  logic              clk_inv;
  logic [LFSR_W-1:0] lfsr_st;

  logic              lane_ref  [LANES];
  logic [TAP_W-1:0]  lane_tap  [LANES];
  logic              lane_flip [LANES];
  logic              lane_q    [LANES];

  pd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  pd_phase #(.TPB(TICKS_PER_BIT), .PH_W(PH_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tick_en (tick_en),
    .din     (din),
    .ph      (ph),
    .bit_end (bit_end),
    .ref_clk (ref_clk),
    .ref_dat (ref_dat)
  );

  pd_ctrl #(.TPB(TICKS_PER_BIT), .TAP_W(TAP_W), .SEED(LFSR_SEED)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .bit_end     (bit_end),
    .mode_sel    (mode_sel),
    .amt_sel     (amt_sel),
    .rate_sel    (rate_sel),
    .clk_tap     (clk_tap),
    .dat_tap     (dat_tap),
    .clk_inv     (clk_inv),
    .cfg_err     (cfg_err),
    .dist_active (dist_active),
    .lfsr_q      (lfsr_st)
  );

  // lane 0 carries the clock, lane 1 the data
  assign lane_ref[0]  = ref_clk;
  assign lane_tap[0]  = clk_tap;
  assign lane_flip[0] = clk_inv;
  assign lane_ref[1]  = ref_dat;
  assign lane_tap[1]  = dat_tap;
  assign lane_flip[1] = 1'b0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pd_lane #(.DEPTH(DEPTH), .TAP_W(TAP_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .tick_en  (tick_en),
      .ref_in   (lane_ref[g]),
      .tap      (lane_tap[g]),
      .flip     (lane_flip[g]),
      .lane_out (lane_q[g])
    );
  end

  assign clk_out = lane_q[0];
  assign dat_out = lane_q[1];
endmodule

// File: rtl/pd_chk.sv
module pd_chk #(
  parameter int TPB  = 8,
  parameter int PH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_en,
  input logic [PH_W-1:0] ph,
  input logic [1:0]      rate_sel,
  input logic            clk_out,
  input logic            dat_out,
  input logic            cfg_err,
  input logic            dist_active,
  input logic [15:0]     lfsr
);
  AST_ERR_ACT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_err && dist_active)); // R13

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(clk_out) && $stable(dat_out) &&
                  $stable(cfg_err) && $stable(dist_active))); // R14

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg_err) || !$stable(dist_active)) |->
      ($past(tick_en) && $past(ph) == PH_W'(TPB - 1))); // R12

  AST_HIGH_RATE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dist_active) |-> ($past(rate_sel) < 2'd2)); // R9

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'd0); // R5
endmodule

bind clk_data_distorter pd_chk #(.TPB(TICKS_PER_BIT), .PH_W(PH_W)) u_pd_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .tick_en     (tick_en),
  .ph          (ph),
  .rate_sel    (rate_sel),
  .clk_out     (clk_out),
  .dat_out     (dat_out),
  .cfg_err     (cfg_err),
  .dist_active (dist_active),
  .lfsr        (lfsr_st)
);

// File: tb/clk_data_distorter_bench.sv
module clk_data_distorter_bench;
  localparam int TPB = 8;
  localparam int NOM = 2;

  logic clk = 1'b0;
  logic rst_n, tick_en, din, amt_sel;
  logic [2:0] mode_sel;
  logic [1:0] rate_sel;
  logic clk_out, dat_out, cfg_err, dist_active;

  always #10 clk = ~clk;

  clk_data_distorter u_clk_data_distorter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .din(din),
    .mode_sel(mode_sel), .amt_sel(amt_sel), .rate_sel(rate_sel),
    .clk_out(clk_out), .dat_out(dat_out),
    .cfg_err(cfg_err), .dist_active(dist_active));

  typedef struct {
    logic  cl, ch, dl, dh, err, act, hold, last;
    string req;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  logic  bits [0:4095];
  int    k = 0;
  int    m_cl = NOM, m_ch = NOM, m_dl = NOM, m_dh = NOM;
  logic  m_inv = 1'b0, m_err = 1'b0, m_act = 1'b0;
  string cur_req = "R2";
  int    seen_cl, seen_ch, seen_dl, seen_dh;
  logic  prev_c = 1'b0, prev_d = 1'b0, prev_e = 1'b0, prev_a = 1'b0;
  logic  okcl = 1'b1, okch = 1'b1, okdl = 1'b1, okdh = 1'b1;
  logic  bad_c_act, bad_c_exp, bad_d_act, bad_d_exp;

  function automatic logic rclk(int t);
    return (t >= 0) && ((t % TPB) < TPB / 2);
  endfunction

  function automatic logic rdat(int t);
    if (t < TPB) return 1'b0;
    return bits[t / TPB - 1];
  endfunction

  function automatic logic ok_setting(int m, int a, int r);
    if (m == 0) return 1'b1;
    if (m == 7) return 1'b0;
    if (r >= 2) return 1'b0;
    if (m == 5 && a == 1) return 1'b0;
    if (r == 1) return (a == 1) && (m >= 1) && (m <= 4);
    return 1'b1;
  endfunction

  task automatic model_update();
    int   a;
    logic lg;
    a  = amt_sel ? 2 : 1;
    lg = ok_setting(int'(mode_sel), int'(amt_sel), int'(rate_sel));
    m_cl = NOM; m_ch = NOM; m_dl = NOM; m_dh = NOM; m_inv = 1'b0;
    if (lg) begin
      case (int'(mode_sel))
        1: begin m_dl = NOM - a; m_dh = NOM - a; end
        2: begin m_dl = NOM + a; m_dh = NOM + a; end
        3: begin m_cl = NOM - a; m_ch = NOM + a; end
        4: begin m_dl = NOM - a; m_dh = NOM + a; end
        5: begin m_cl = NOM - 1; m_ch = NOM + 1; m_dl = NOM - 1; m_dh = NOM + 1; end
        6: m_inv = 1'b1;
        default: ;
      endcase
    end
    m_err = !lg;
    m_act = lg && (mode_sel != 3'd0);
  endtask

  // driver: one item per cycle, pushed before the edge it describes
  task automatic tick(input logic en);
    item_t it;
    @(negedge clk);
    tick_en = en;
    it.req  = cur_req;
    it.hold = !en;
    it.last = 1'b0;
    it.cl = 1'b0; it.ch = 1'b0; it.dl = 1'b0; it.dh = 1'b0;
    it.err = m_err; it.act = m_act;
    if (en) begin
      din   = bits[k / TPB];
      it.cl = rclk(k - m_cl) ^ m_inv;
      it.ch = rclk(k - m_ch) ^ m_inv;
      it.dl = rdat(k - m_dl);
      it.dh = rdat(k - m_dh);
      if (k % TPB == TPB - 1) begin
        it.last = 1'b1;
        model_update();
      end
      it.err = m_err;
      it.act = m_act;
      k++;
    end
    q.push_back(it);
  endtask

  task automatic flush();
    tick(1'b0);
    @(negedge clk);
  endtask

  task automatic seg(string req, int m, int a, int r, int nbits, bit want_c, bit want_d);
    flush();
    seen_cl = 0; seen_ch = 0; seen_dl = 0; seen_dh = 0;
    cur_req  = req;
    mode_sel = 3'(m);
    amt_sel  = 1'(a);
    rate_sel = 2'(r);
    for (int i = 0; i < nbits * TPB; i++) tick(1'b1);
    flush();
    if (want_c) begin
      checks++;
      if (seen_cl == 0 || seen_ch == 0) begin
        errors++;
        $display("FAIL %s clock jitter signs seen early=%0d late=%0d, expected both nonzero",
                 req, seen_cl, seen_ch);
      end
    end
    if (want_d) begin
      checks++;
      if (seen_dl == 0 || seen_dh == 0) begin
        errors++;
        $display("FAIL %s data jitter signs seen early=%0d late=%0d, expected both nonzero",
                 req, seen_dl, seen_dh);
      end
    end
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.hold) begin
          checks++;
          if ({clk_out, dat_out, cfg_err, dist_active} != {prev_c, prev_d, prev_e, prev_a}) begin
            errors++;
            $display("FAIL R14 (%s) outputs moved without tick: actual %b expected %b",
                     it.req, {clk_out, dat_out, cfg_err, dist_active},
                     {prev_c, prev_d, prev_e, prev_a});
          end
        end else begin
          if (okcl && clk_out != it.cl) begin bad_c_act = clk_out; bad_c_exp = it.cl; end
          if (okdl && dat_out != it.dl) begin bad_d_act = dat_out; bad_d_exp = it.dl; end
          okcl &= (clk_out == it.cl);
          okch &= (clk_out == it.ch);
          okdl &= (dat_out == it.dl);
          okdh &= (dat_out == it.dh);
          checks++;
          if (cfg_err != it.err) begin
            errors++;
            $display("FAIL %s R12 cfg_err actual %b expected %b", it.req, cfg_err, it.err);
          end
          checks++;
          if (dist_active != it.act) begin
            errors++;
            $display("FAIL %s R13 dist_active actual %b expected %b", it.req, dist_active, it.act);
          end
          if (it.last) begin
            checks++;
            if (!(okcl || okch)) begin
              errors++;
              $display("FAIL %s clock lane: actual %b expected %b in bit window",
                       it.req, bad_c_act, bad_c_exp);
            end else if (okcl && !okch) seen_cl++;
            else if (okch && !okcl) seen_ch++;
            checks++;
            if (!(okdl || okdh)) begin
              errors++;
              $display("FAIL %s data lane: actual %b expected %b in bit window",
                       it.req, bad_d_act, bad_d_exp);
            end else if (okdl && !okdh) seen_dl++;
            else if (okdh && !okdl) seen_dh++;
            okcl = 1'b1; okch = 1'b1; okdl = 1'b1; okdh = 1'b1;
          end
        end
        prev_c = clk_out; prev_d = dat_out; prev_e = cfg_err; prev_a = dist_active;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) bits[i] = 1'($urandom_range(0, 1));
    rst_n = 1'b0; tick_en = 1'b0; din = 1'b0;
    mode_sel = 3'd0; amt_sel = 1'b0; rate_sel = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({clk_out, dat_out, cfg_err, dist_active} != 4'b0000) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b expected 0000",
               {clk_out, dat_out, cfg_err, dist_active});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if ({clk_out, dat_out, cfg_err, dist_active} != 4'b0000) begin
      errors++;
      $display("FAIL R1 after release actual %b expected 0000",
               {clk_out, dat_out, cfg_err, dist_active});
    end

    seg("R2", 0, 0, 0, 6, 0, 0);
    seg("R3", 1, 0, 0, 4, 0, 0);
    seg("R3", 1, 1, 0, 4, 0, 0);
    seg("R4", 2, 0, 0, 4, 0, 0);
    seg("R4", 2, 1, 0, 4, 0, 0);
    seg("R5", 3, 0, 0, 24, 1, 0);
    seg("R5", 3, 1, 0, 24, 1, 0);
    seg("R6", 4, 0, 0, 24, 0, 1);
    seg("R6", 4, 1, 0, 24, 0, 1);
    seg("R7", 5, 0, 0, 24, 1, 1);
    seg("R7", 5, 1, 0, 4, 0, 0);
    seg("R8", 6, 0, 0, 4, 0, 0);
    seg("R9", 1, 1, 2, 4, 0, 0);
    seg("R9", 3, 1, 3, 4, 0, 0);
    seg("R9", 0, 0, 2, 3, 0, 0);
    seg("R10", 1, 1, 1, 4, 0, 0);
    seg("R10", 1, 0, 1, 4, 0, 0);
    seg("R10", 3, 1, 1, 24, 1, 0);
    seg("R10", 5, 0, 1, 4, 0, 0);
    seg("R10", 6, 0, 1, 4, 0, 0);
    seg("R11", 7, 0, 0, 4, 0, 0);
    seg("R11", 7, 1, 1, 3, 0, 0);
    seg("R13", 0, 0, 0, 3, 0, 0);

    // R14: sparse ticks with a lag setting
    flush();
    cur_req = "R14"; mode_sel = 3'd2; amt_sel = 1'b1; rate_sel = 2'd0;
    for (int i = 0; i < 6 * TPB * 3; i++) tick((i % 3) != 0);
    flush();
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule